// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Normalizer

This block sits in front of a downstream interrupt controller that accepts only active-high levels and rising edges. It serves a bank of wakeup-capable interrupt inputs. Each input line has its own configuration word on a simple 32-bit register bus. That word selects one of five trigger types and carries an enable bit. Active-low levels leave the block inverted as active-high levels. Falling-edge events and both-edge events leave as single-cycle rising pulses. Active-high levels and rising edges pass through with their sense unchanged. The downstream controller can therefore be set up as "high level" or "rising edge" for every line.

Each input first passes through a two-flop synchronizer. The edge detector compares the synchronized value against a one-cycle-old sample of the same raw signal. It never compares against a polarity-adjusted copy. Because of this, rewriting the trigger type on a line whose input is steady produces no false event. A read-only identification word reports revision 3.2.0.

Top module: `wake_irq_normalizer`

## Requirements
- R1: After reset every configuration word reads 0, and every output line is low.
- R2: Line i's configuration word sits at byte address 0x110 + 4*i and holds all 32 written bits. Reads return 0 at any unmapped address, including unaligned addresses and addresses past the last line.
- R3: Byte address 0x1000 always reads 0x00030200: major 3 in bits [23:16], minor 2 in [15:8], step 0 in [7:0]. Writes to it have no effect.
- R4: Trigger type 3'b100 (bits [2:0]) with enable bit 3 set drives the output high while the input is high. The output follows the input 3 clock edges later.
- R5: Trigger type 3'b000 with enable set drives the output high while the input is low.
- R6: Trigger type 3'b110 with enable set gives exactly one single-cycle output pulse per rising input transition, and none on a falling transition.
- R7: Trigger type 3'b010 with enable set gives exactly one single-cycle output pulse per falling input transition, and none on a rising transition.
- R8: Trigger type 3'b111 with enable set gives exactly one single-cycle output pulse on every input transition.
- R9: While enable bit 3 is clear, the line's output stays low whatever the input does.
- R10: The unused type codes 3'b001, 3'b011 and 3'b101 produce no output, even with enable set.
- R11: Rewriting a line's trigger type among the edge types while its input is steady produces no output pulse.
- R12: A write to one line's configuration word changes neither another line's word nor another line's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_LINES | Raw interrupt inputs, asynchronous |
| irq_out | output | NUM_LINES | Normalized outputs: active-high levels or single-cycle rising pulses |

## Verification
The bench targets retyping on a steady input. It holds a line high or low and cycles the type between rising, falling and both-edge codes. A design that ran the edge detector on a polarity-inverted signal would emit a pulse on each rewrite. It also counts pulses per transition in both-edge mode, where a detector that looked at only one direction would miss half the events. It also checks that pulses last only one cycle, where a level-style implementation would hold the output high. The unused type codes, a line whose enable is cleared while the input is active, and the unmapped addresses around the line window are also covered. A faulty decoder in those cases would leak output or alias registers.

// File: rtl/wirq_pkg.sv
`timescale 1ns/1ps
package wirq_pkg;
  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'b000,
    TRIG_FALL   = 3'b010,
    TRIG_LVL_HI = 3'b100,
    TRIG_RISE   = 3'b110,
    TRIG_BOTH   = 3'b111
  } trig_e;

  localparam int          ENABLE_BIT = 3;
  localparam int          CFG_BASE   = 32'h0000_0110;
  localparam int          ID_ADDR    = 32'h0000_1000;
  localparam logic [31:0] ID_WORD    = 32'h0003_0200;
endpackage

// File: rtl/wirq_sync.sv
`timescale 1ns/1ps
module wirq_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;
endmodule

// File: rtl/wirq_regfile.sv
`timescale 1ns/1ps
module wirq_regfile
  import wirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wen,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [NUM_LINES-1:0][3:0] line_ctl,
  output logic [NUM_LINES-1:0]      retype
);
  localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_ADDR);

  logic [NUM_LINES-1:0][31:0] cfg_q;
  logic [NUM_LINES-1:0][31:0] rd_term;
  logic [NUM_LINES-1:0]       hit;
  logic [NUM_LINES-1:0]       wr_en;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [ADDR_W-1:0] LINE_A = ADDR_W'(CFG_BASE + 4 * i);

    assign hit[i]      = (bus_addr == LINE_A);
    assign wr_en[i]    = hit[i] & bus_wen;
    assign retype[i]   = wr_en[i] & (bus_wdata[2:0] != cfg_q[i][2:0]);
    assign line_ctl[i] = cfg_q[i][3:0];
    assign rd_term[i]  = hit[i] ? cfg_q[i] : 32'h0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (wr_en[i]) begin
        cfg_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = (bus_addr == ID_A) ? ID_WORD : 32'h0;
    for (int i = 0; i < NUM_LINES; i++) begin
      bus_rdata = bus_rdata | rd_term[i];
    end
  end
endmodule

// File: rtl/wirq_line.sv
`timescale 1ns/1ps
module wirq_line
  import wirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ctl,
  input  logic       retype,
  input  logic       lvl,
  output logic       irq
);
  logic prev_q;
  logic out_q;
  logic out_d;
  logic went_up;
  logic went_down;
  logic fire;

  always_comb begin
    went_up   = lvl & ~prev_q;
    went_down = ~lvl & prev_q;
    case (ctl[2:0])
      TRIG_LVL_LO: fire = ~lvl;
      TRIG_LVL_HI: fire = lvl;
      TRIG_RISE:   fire = went_up & ~retype;
      TRIG_FALL:   fire = went_down & ~retype;
      TRIG_BOTH:   fire = (went_up | went_down) & ~retype;
      default:     fire = 1'b0;
    endcase
    out_d = fire & ctl[ENABLE_BIT];
  end

  // The previous-sample register always tracks the raw synchronized level.
  // A type write therefore re-arms it with the present value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      out_q  <= out_d;
    end
  end

  assign irq = out_q;
endmodule

// File: rtl/wake_irq_normalizer.sv
`timescale 1ns/1ps
module wake_irq_normalizer
  import wirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wen,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [1:0]                rst_pipe;
  logic                      rst_nq;
  logic [NUM_LINES-1:0]      irq_lvl;
  logic [NUM_LINES-1:0][3:0] line_ctl;
  logic [NUM_LINES-1:0]      retype;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_nq = rst_pipe[1];

  wirq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_nq),
    .async_in (irq_in),
    .sync_out (irq_lvl)
  );

  wirq_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_nq),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .line_ctl  (line_ctl),
    .retype    (retype)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_ch
    wirq_line u_line (
      .clk    (clk),
      .rst_n  (rst_nq),
      .ctl    (line_ctl[i]),
      .retype (retype[i]),
      .lvl    (irq_lvl[i]),
      .irq    (irq_out[i])
    );
  end
endmodule

// File: rtl/wirq_checker.sv
`timescale 1ns/1ps
module wirq_checker
  import wirq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 13
) (
  input logic                      clk,
  input logic                      rst_nq,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_rdata,
  input logic [NUM_LINES-1:0][3:0] line_ctl,
  input logic [NUM_LINES-1:0]      line_lvl,
  input logic [NUM_LINES-1:0]      irq_out
);
  localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_ADDR);

  function automatic logic is_edge(input logic [3:0] c);
    return (c[2:0] == 3'b010) || (c[2:0] == 3'b110) || (c[2:0] == 3'b111);
  endfunction

  function automatic logic is_single(input logic [3:0] c);
    return (c[2:0] == 3'b010) || (c[2:0] == 3'b110);
  endfunction

  function automatic logic is_unused(input logic [3:0] c);
    return (c[2:0] == 3'b001) || (c[2:0] == 3'b011) || (c[2:0] == 3'b101);
  endfunction

  AST_ID_WORD: assert property (@(posedge clk) disable iff (!rst_nq)
    (bus_addr == ID_A) |-> (bus_rdata == ID_WORD)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_nq)
    (bus_addr == '0) |-> (bus_rdata == 32'h0)); // R2

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_nq)
      (line_ctl[i] == 4'b1100 && $stable(line_ctl[i])) |=>
        (irq_out[i] == $past(line_lvl[i]))); // R4

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_nq)
      (irq_out[i] && is_single(line_ctl[i]) && $stable(line_ctl[i])) |=>
        !irq_out[i]); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_nq)
      (!line_ctl[i][ENABLE_BIT] && $stable(line_ctl[i])) |=> !irq_out[i]); // R9

    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_nq)
      (is_unused(line_ctl[i]) && $stable(line_ctl[i])) |=> !irq_out[i]); // R10

    AST_STEADY_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_nq)
      ($stable(line_lvl[i]) && is_edge(line_ctl[i])) |=> !irq_out[i]); // R11
  end
endmodule

bind wake_irq_normalizer wirq_checker #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_nq    (rst_nq),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .line_ctl  (line_ctl),
  .line_lvl  (irq_lvl),
  .irq_out   (irq_out)
);

// File: tb/tb_wake_irq_normalizer.sv
`timescale 1ns/1ps
module tb_wake_irq_normalizer;
  localparam int NL = 16;
  localparam int AW = 13;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wen;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in;
  logic [NL-1:0] irq_out;

  int total;
  int bad;
  bit done;

  wake_irq_normalizer #(.NUM_LINES(NL), .ADDR_W(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] cfg_addr(input int line);
    return AW'(32'h110 + 4 * line);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wen   = 1'b1;
    @(negedge clk);
    bus_wen   = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic count_pulses(input int line, input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq_out[line]) c++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(cfg_addr(i), d);
      chk("R1 cfg after reset", d, 32'h0);
    end
    chk("R1 outputs after reset", 32'(irq_out), 32'h0);
    rd(AW'(32'h1000), d);
    chk("R3 id word", d, 32'h0003_0200);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(cfg_addr(2), 32'hA5A5_F009);
    rd(cfg_addr(2), d);
    chk("R2 full readback", d, 32'hA5A5_F009);
    rd(cfg_addr(1), d);
    chk("R12 neighbour below untouched", d, 32'h0);
    rd(cfg_addr(3), d);
    chk("R12 neighbour above untouched", d, 32'h0);
    rd(cfg_addr(NL), d);
    chk("R2 past last line reads zero", d, 32'h0);
    rd(AW'(32'h112), d);
    chk("R2 unaligned reads zero", d, 32'h0);
    wr(AW'(32'h1000), 32'h0);
    rd(AW'(32'h1000), d);
    chk("R3 id word ignores write", d, 32'h0003_0200);
    wr(cfg_addr(2), 32'h0);
    rd(cfg_addr(2), d);
    chk("R2 cleared", d, 32'h0);
  endtask

  task automatic t_level();
    int c;
    wr(cfg_addr(0), 32'h0000_000C);
    irq_in[0] = 1'b1;
    tick(3);
    chk("R4 high level passes", 32'(irq_out[0]), 32'h1);
    irq_in[0] = 1'b0;
    tick(3);
    chk("R4 low input gives low", 32'(irq_out[0]), 32'h0);

    wr(cfg_addr(1), 32'h0000_0008);
    tick(2);
    chk("R5 low input gives high", 32'(irq_out[1]), 32'h1);
    irq_in[1] = 1'b1;
    tick(3);
    chk("R5 high input gives low", 32'(irq_out[1]), 32'h0);
    irq_in[1] = 1'b0;
    tick(3);
    chk("R5 returns high", 32'(irq_out[1]), 32'h1);
    wr(cfg_addr(1), 32'h0000_0000);
    tick(2);
    chk("R9 disable forces low", 32'(irq_out[1]), 32'h0);

    irq_in[0] = 1'b1;
    tick(3);
    wr(cfg_addr(0), 32'h0000_0004);
    tick(2);
    chk("R9 disabled level-high line low", 32'(irq_out[0]), 32'h0);
    irq_in[0] = 1'b0;
    count_pulses(0, 4, c);
    irq_in[0] = 1'b1;
    count_pulses(0, 4, c);
    chk("R9 no output while disabled", 32'(c), 32'h0);
    irq_in[0] = 1'b0;
    tick(4);
  endtask

  task automatic t_rise();
    int c;
    wr(cfg_addr(0), 32'h0000_000E);
    tick(3);
    irq_in[0] = 1'b1;
    tick(3);
    chk("R6 pulse on rise", 32'(irq_out[0]), 32'h1);
    tick(1);
    chk("R6 pulse lasts one cycle", 32'(irq_out[0]), 32'h0);
    count_pulses(0, 4, c);
    chk("R6 no repeat while high", 32'(c), 32'h0);
    irq_in[0] = 1'b0;
    count_pulses(0, 6, c);
    chk("R6 no pulse on fall", 32'(c), 32'h0);
  endtask

  task automatic t_fall();
    int c;
    wr(cfg_addr(0), 32'h0000_000A);
    tick(2);
    irq_in[0] = 1'b1;
    count_pulses(0, 6, c);
    chk("R7 no pulse on rise", 32'(c), 32'h0);
    irq_in[0] = 1'b0;
    tick(3);
    chk("R7 pulse on fall", 32'(irq_out[0]), 32'h1);
    tick(1);
    chk("R7 pulse lasts one cycle", 32'(irq_out[0]), 32'h0);
  endtask

  task automatic t_both();
    int c;
    wr(cfg_addr(0), 32'h0000_000F);
    tick(2);
    irq_in[0] = 1'b1;
    count_pulses(0, 6, c);
    chk("R8 one pulse on rise", 32'(c), 32'h1);
    irq_in[0] = 1'b0;
    count_pulses(0, 6, c);
    chk("R8 one pulse on fall", 32'(c), 32'h1);
  endtask

  task automatic t_unused();
    int c;
    int total_c;
    logic [31:0] codes [3];
    codes[0] = 32'h9;
    codes[1] = 32'hB;
    codes[2] = 32'hD;
    for (int k = 0; k < 3; k++) begin
      total_c = 0;
      wr(cfg_addr(0), codes[k]);
      irq_in[0] = 1'b1;
      count_pulses(0, 5, c);
      total_c += c;
      irq_in[0] = 1'b0;
      count_pulses(0, 5, c);
      total_c += c;
      chk("R10 unused code silent", 32'(total_c), 32'h0);
    end
  endtask

  task automatic t_retype();
    int c;
    wr(cfg_addr(0), 32'h0000_000E);
    irq_in[0] = 1'b1;
    tick(6);
    wr(cfg_addr(0), 32'h0000_000A);
    count_pulses(0, 6, c);
    chk("R11 high steady rise to fall", 32'(c), 32'h0);
    wr(cfg_addr(0), 32'h0000_000F);
    count_pulses(0, 6, c);
    chk("R11 high steady fall to both", 32'(c), 32'h0);
    wr(cfg_addr(0), 32'h0000_000E);
    count_pulses(0, 6, c);
    chk("R11 high steady both to rise", 32'(c), 32'h0);
    irq_in[0] = 1'b0;
    tick(6);
    wr(cfg_addr(0), 32'h0000_000A);
    count_pulses(0, 6, c);
    chk("R11 low steady rise to fall", 32'(c), 32'h0);
    wr(cfg_addr(0), 32'h0000_000F);
    count_pulses(0, 6, c);
    chk("R11 low steady fall to both", 32'(c), 32'h0);
    irq_in[0] = 1'b1;
    count_pulses(0, 6, c);
    chk("R11 real edge after retype", 32'(c), 32'h1);
    chk("R12 idle line stays low", 32'(irq_out[3]), 32'h0);
    wr(cfg_addr(0), 32'h0);
    irq_in[0] = 1'b0;
  endtask

  initial begin
    total     = 0;
    bad       = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wen   = 1'b0;
    bus_wdata = '0;
    irq_in    = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_regs();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_unused();
    t_retype();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule